// File: doc/BRIEF.md
# Event Counting Gate Generator

This block forms the enable window for a pair of gated event counters. The window comes from one of two sources. The first is an internal gate-control level, which stands in for the timers that make fixed gates (1 us to 1 s) and gates delayed or scanned from an external trigger. The second is a discriminated external input. Both sources go through a single XOR with the control bit. The rising edge of the XOR result sets an open flag and the rising edge of its inverse (a falling edge of the result) sets a close flag. The gate output is high while the open flag is set and the close flag is not.

A load pulse arms the block. It clears both flags and records the current level of the XOR result, so arming never counts as an edge. After the close flag is set, the gate stays low until the next load. A close edge that comes before any open edge therefore gives a window that never opens. The external input is asynchronous and is passed through a synchronizer of `SYNC_STAGES` flops before the XOR. In external mode the control bit only selects the gate polarity.

Top module: `evg_gate_gen`

## Requirements
- R1: After reset the gate is low, and it stays low until the first load pulse, whatever the other inputs do. One cycle after a load pulse is sampled, the gate is low.
- R2: Internal mode is selected by `mode_ext_i`=0. In this mode a rising edge of `ctrl_i` raises the gate on the next clock edge, and a falling edge of `ctrl_i` lowers it on the next clock edge.
- R3: External mode is selected by `mode_ext_i`=1 with `holdoff_en_i`=1, and here `ctrl_i`=0 gives positive polarity. A rising edge of `ext_i` raises the gate SYNC_STAGES+1 clock edges after it is first sampled, and a falling edge of `ext_i` closes the gate.
- R4: In external mode with `ctrl_i`=1 the polarity is inverted. A falling edge of `ext_i` opens the gate and a rising edge of `ext_i` closes it.
- R5: `ext_i` has no effect on the gate when `holdoff_en_i`=0 or when `mode_ext_i`=0.
- R6: Once the gate has closed, further opening edges are ignored until the next load. A new load re-arms the block.
- R7: If a closing edge arrives before any opening edge after a load, the gate never opens before the next load.
- R8: A load never produces an edge by itself. If the XOR result is already high when the load is sampled, the gate does not open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Arm pulse: clears both flags and captures the current level |
| mode_ext_i | input | 1 | 1 = external gating, 0 = internal control |
| holdoff_en_i | input | 1 | 1 lets the external input reach the XOR |
| ctrl_i | input | 1 | Internal gate level, or external polarity (1 = inverted) |
| ext_i | input | 1 | Discriminated external input (asynchronous) |
| gate_o | output | 1 | Event counting enable window |

## Verification
The assertions assume that `mode_ext_i` and `holdoff_en_i` change only at a load or while the block is idle. They also assume that `ctrl_i` is a clean synchronous level, so that a change in `ctrl_i` in internal mode is itself the edge the flags see. The bench drives every input one time step after a rising clock edge. It changes mode and polarity only before a load, and it waits long enough for the synchronizer to settle before arming the block. Because of this, each recorded level matches the source that was chosen.

// File: rtl/evg_pkg.sv
package evg_pkg;

    typedef struct packed {
        logic opened;
        logic closed;
        logic prev;
    } gate_state_t;

endpackage

// File: rtl/evg_sync.sv
module evg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[0] <= 1'b0;
                    else         chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[g] <= 1'b0;
                    else         chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/evg_edge.sv
module evg_edge (
    input  logic level_i,
    input  logic prev_i,
    output logic rise_o,
    output logic fall_o
);
    always_comb begin
        rise_o = level_i & ~prev_i;
        fall_o = ~level_i & prev_i;
    end
endmodule

// File: rtl/evg_gate_gen.sv
module evg_gate_gen #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic mode_ext_i,
    input  logic holdoff_en_i,
    input  logic ctrl_i,
    input  logic ext_i,
    output logic gate_o
);
    import evg_pkg::*;

    gate_state_t st_d, st_q;
    logic ext_sync;
    logic ext_term;
    logic src_lvl;
    logic src_rise;
    logic src_fall;

    evg_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (ext_i),
        .sync_o  (ext_sync)
    );

    always_comb begin
        ext_term = ext_sync & mode_ext_i & holdoff_en_i;
        src_lvl  = ext_term ^ ctrl_i;
    end

    evg_edge i_edge (
        .level_i (src_lvl),
        .prev_i  (st_q.prev),
        .rise_o  (src_rise),
        .fall_o  (src_fall)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = src_lvl;
        if (load_i) begin
            st_d.opened = 1'b0;
            st_d.closed = 1'b0;
        end else if (!st_q.closed) begin
            if (src_fall)                  st_d.closed = 1'b1;
            else if (src_rise && !st_q.opened) st_d.opened = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.opened <= 1'b0;
            st_q.closed <= 1'b1;
            st_q.prev   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o = st_q.opened & ~st_q.closed;
endmodule

// File: rtl/evg_gate_chk.sv
module evg_gate_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic load_i,
    input logic mode_ext_i,
    input logic holdoff_en_i,
    input logic ctrl_i,
    input logic gate_o
);
    logic armed_q;
    logic was_open_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            armed_q    <= 1'b0;
            was_open_q <= 1'b0;
        end else begin
            if (load_i) armed_q <= 1'b1;
            if (load_i)      was_open_q <= 1'b0;
            else if (gate_o) was_open_q <= 1'b1;
        end
    end

    p_idle_before_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !armed_q |-> !gate_o);

    p_load_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> !gate_o);

    p_ctrl_close_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mode_ext_i && $stable(mode_ext_i) && gate_o && $fell(ctrl_i) && !load_i) |=> !gate_o);

    p_ext_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((!holdoff_en_i || !mode_ext_i) && $stable(holdoff_en_i) && $stable(mode_ext_i)
         && $stable(ctrl_i) && !load_i) |=> $stable(gate_o));

    p_stays_closed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (was_open_q && !gate_o && !load_i) |=> !gate_o);

    p_no_open_from_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(gate_o) |-> !$past(load_i));
endmodule

bind evg_gate_gen evg_gate_chk i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load_i),
    .mode_ext_i   (mode_ext_i),
    .holdoff_en_i (holdoff_en_i),
    .ctrl_i       (ctrl_i),
    .gate_o       (gate_o)
);

// File: tb/test_evg_gate_gen.sv
`timescale 1ns/1ps
module test_evg_gate_gen;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load = 1'b0;
    logic mode_ext = 1'b0;
    logic holdoff = 1'b0;
    logic ctrl = 1'b0;
    logic ext = 1'b0;
    logic gate;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    evg_gate_gen #(.SYNC_STAGES(SYNC)) i_evg_gate_gen (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .load_i       (load),
        .mode_ext_i   (mode_ext),
        .holdoff_en_i (holdoff),
        .ctrl_i       (ctrl),
        .ext_i        (ext),
        .gate_o       (gate)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic arm();
        load = 1'b1;
        step(1);
        load = 1'b0;
    endtask

    task automatic t_reset();
        check(gate, 1'b0, "R1 gate low in reset");
        rst_n = 1'b1;
        step(2);
        mode_ext = 1'b0;
        ctrl = 1'b1;
        step(2);
        check(gate, 1'b0, "R1 no window before first load");
        ctrl = 1'b0;
        step(2);
    endtask

    task automatic t_internal();
        mode_ext = 1'b0; holdoff = 1'b0; ctrl = 1'b0;
        arm();
        check(gate, 1'b0, "R1 gate low after load");
        ctrl = 1'b1;
        step(1);
        check(gate, 1'b1, "R2 ctrl rise opens after one edge");
        step(3);
        check(gate, 1'b1, "R2 gate held while ctrl high");
        ctrl = 1'b0;
        step(1);
        check(gate, 1'b0, "R2 ctrl fall closes after one edge");
    endtask

    task automatic t_load_during_open();
        mode_ext = 1'b0; ctrl = 1'b0;
        arm();
        ctrl = 1'b1;
        step(2);
        check(gate, 1'b1, "R2 open before reload");
        arm();
        check(gate, 1'b0, "R1 load clears open window");
        ctrl = 1'b0;
        step(2);
    endtask

    task automatic t_ext_pos();
        mode_ext = 1'b1; holdoff = 1'b1; ctrl = 1'b0; ext = 1'b0;
        step(SYNC + 1);
        arm();
        ext = 1'b1;
        step(SYNC);
        check(gate, 1'b0, "R3 not yet open before sync latency");
        step(1);
        check(gate, 1'b1, "R3 ext rise opens after SYNC+1 edges");
        ext = 1'b0;
        step(SYNC + 2);
        check(gate, 1'b0, "R3 ext fall closes");
    endtask

    task automatic t_ext_neg();
        mode_ext = 1'b1; holdoff = 1'b1; ctrl = 1'b1; ext = 1'b1;
        step(SYNC + 1);
        arm();
        ext = 1'b0;
        step(SYNC + 2);
        check(gate, 1'b1, "R4 inverted: ext fall opens");
        ext = 1'b1;
        step(SYNC + 2);
        check(gate, 1'b0, "R4 inverted: ext rise closes");
    endtask

    task automatic t_ignore();
        mode_ext = 1'b1; holdoff = 1'b0; ctrl = 1'b0; ext = 1'b0;
        step(SYNC + 1);
        arm();
        ext = 1'b1;
        step(SYNC + 3);
        check(gate, 1'b0, "R5 ext ignored with holdoff off (rise)");
        ext = 1'b0;
        step(SYNC + 3);
        check(gate, 1'b0, "R5 ext ignored with holdoff off (fall)");
        mode_ext = 1'b0; holdoff = 1'b1; ctrl = 1'b0;
        step(SYNC + 1);
        arm();
        ext = 1'b1;
        step(SYNC + 3);
        check(gate, 1'b0, "R5 ext ignored in internal mode");
        ctrl = 1'b1;
        step(1);
        check(gate, 1'b1, "R5 internal ctrl still opens with ext high");
        ext = 1'b0;
        step(SYNC + 3);
        check(gate, 1'b1, "R5 ext fall ignored in internal mode");
        ctrl = 1'b0;
        step(1);
    endtask

    task automatic t_sticky();
        mode_ext = 1'b0; holdoff = 1'b0; ctrl = 1'b0;
        arm();
        ctrl = 1'b1; step(2);
        ctrl = 1'b0; step(2);
        ctrl = 1'b1; step(2);
        check(gate, 1'b0, "R6 second open edge ignored after close");
        ctrl = 1'b0; step(1);
        arm();
        ctrl = 1'b1; step(1);
        check(gate, 1'b1, "R6 new load re-arms");
        ctrl = 1'b0; step(1);
    endtask

    task automatic t_close_first();
        mode_ext = 1'b0; ctrl = 1'b1;
        step(1);
        arm();
        check(gate, 1'b0, "R8 high level at load does not open");
        ctrl = 1'b0; step(2);
        ctrl = 1'b1; step(2);
        check(gate, 1'b0, "R7 close before open keeps gate shut");
        ctrl = 1'b0; step(1);
    endtask

    task automatic t_ext_level();
        mode_ext = 1'b1; holdoff = 1'b1; ctrl = 1'b1; ext = 1'b0;
        step(SYNC + 1);
        arm();
        step(SYNC + 2);
        check(gate, 1'b0, "R8 inverted idle level at load is not an edge");
        ext = 1'b1; step(SYNC + 2);
        ext = 1'b0; step(SYNC + 2);
        check(gate, 1'b0, "R7 external close before open keeps gate shut");
    endtask

    initial begin
        step(3);
        t_reset();
        t_internal();
        t_load_during_open();
        t_ext_pos();
        t_ext_neg();
        t_ignore();
        t_sticky();
        t_close_first();
        t_ext_level();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1..: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule